// File: doc/BRIEF.md
# Pipelined Sine/Cosine Rotation Engine

This block turns a stream of phase angles into sine and cosine values using shift-and-add coordinate rotation. It is fully unrolled. Each micro-rotation is its own hardware stage with a register behind it, and nothing is reused from one iteration to the next. Each stage's shift distance is set by how the wires are connected. Its arctangent step is a constant built into that stage. No controller is needed: a new angle can be offered on every clock, and a result leaves the last stage on every clock once the pipe is full.

The vector enters the first stage already scaled by the reciprocal of the rotation gain, with the other coordinate at zero. The results therefore come out at unit amplitude, and no multiplier follows the pipe. Angles in the two outer quadrants are first folded by a half-turn. That half-turn is absorbed by starting the vector at the negated scaled value, so every stage only ever sees a residual within a quarter-turn of zero.

A valid flag moves through the stage registers with the data. Cycles with no valid input appear as empty output slots exactly one pipeline depth later.

Top module: `sincos_pipe`

## Requirements
- R1: `out_valid` is high in the cycle that falls exactly 14 clock cycles after the cycle in which `in_valid` was sampled high, with the default of 14 stages.
- R2: A new angle is accepted on every clock. A run of back-to-back valid inputs yields an equally long run of back-to-back valid outputs.
- R3: `in_angle` is a signed 16-bit binary angle. The value a stands for a·2π/65536 radians, so 0x4000 is +π/2, 0xC000 is −π/2 and 0x8000 is −π.
- R4: `out_sin` is a signed 16-bit value with 14 fraction bits (1.0 = 16384). For every angle it lies within 6 LSB of round(16384·sin θ).
- R5: `out_cos` uses the same format and lies within 6 LSB of round(16384·cos θ). This holds in all four quadrants, including angles whose two top bits are 01 or 10 and which are therefore folded by a half-turn.
- R6: A synchronous active-high `rst` discards every angle in flight. No `out_valid` appears for an angle that was sampled at or before the last clock on which `rst` was high.
- R7: A cycle with `in_valid` low gives a cycle with `out_valid` low 14 cycles later, whatever value `in_angle` held in that cycle.
- R8: No output scaling is needed. For every valid result, out_sin² + out_cos² lies within 1/64 of 16384².
- R9: The boundary angles 0, +π/2, −π/2, −π, and the codes next to ±π/2 and +π, meet the same 6-LSB bound on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every valid flag |
| in_valid | input | 1 | Marks `in_angle` as a sample to convert |
| in_angle | input | 16 | Signed binary angle, full circle = 2^16 |
| out_valid | output | 1 | Marks the result pair as valid |
| out_sin | output | 16 | Sine, signed, 14 fraction bits |
| out_cos | output | 16 | Cosine, signed, 14 fraction bits |

## Verification
The hardest case to reach from the ports is the interaction between the valid flags in flight and the data they carry. This covers a reset that lands while every stage holds a live sample, and bubbles that must keep their exact slot through all fourteen registers. The stimulus first streams a dense angle sweep with no gaps. It then sends a second stream in which every third cycle is a bubble with a junk angle present on the input, and uses it to place the boundary codes on both sides of each quadrant fold. Finally it asserts reset in the middle of a full pipe, and checks that none of the discarded samples ever appears at the output.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    localparam int SC_DATA_W  = 16;
    localparam int SC_ANGLE_W = 16;
    localparam int SC_STAGES  = 14;
    localparam int SC_GUARD   = 2;

    localparam real SC_PI = 3.14159265358979323846;

    // arctangent of 2^-i in radians, by power series (i >= 1) or pi/4 (i == 0)
    function automatic real atan_pow2(input int i);
        real t;
        real acc;
        real p;
        real term;
        t = 1.0;
        for (int j = 0; j < i; j++) t = t / 2.0;
        if (i == 0) return SC_PI / 4.0;
        acc = 0.0;
        p   = t;
        for (int k = 0; k < 24; k++) begin
            term = p / real'(2 * k + 1);
            if (k % 2 == 1) acc = acc - term;
            else            acc = acc + term;
            p = p * t * t;
        end
        return acc;
    endfunction

    // arctangent step in binary-angle units (full circle = 2^aw)
    function automatic int atan_units(input int i, input int aw);
        real u;
        u = atan_pow2(i) / (2.0 * SC_PI);
        for (int j = 0; j < aw; j++) u = u * 2.0;
        return $rtoi(u + 0.5);
    endfunction

    // reciprocal of the accumulated rotation gain, in fixed point with frac bits
    function automatic int inv_gain_fixed(input int stages, input int frac);
        real g;
        real t;
        g = 1.0;
        t = 1.0;
        for (int i = 0; i < stages; i++) begin
            g = g / $sqrt(1.0 + t * t);
            t = t / 2.0;
        end
        for (int j = 0; j < frac; j++) g = g * 2.0;
        return $rtoi(g + 0.5);
    endfunction

    // quadrant tag derived from the two top bits of a binary angle
    typedef enum logic [1:0] {
        QD_FIRST  = 2'b00,
        QD_SECOND = 2'b01,
        QD_THIRD  = 2'b10,
        QD_FOURTH = 2'b11
    } quadrant_e;

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold
    import sincos_pkg::*;
#(
    parameter int IW      = SC_DATA_W + SC_GUARD,
    parameter int AW      = SC_ANGLE_W,
    parameter int STAGES  = SC_STAGES,
    parameter int IFRAC   = SC_DATA_W - 2 + SC_GUARD
) (
    input  logic [AW-1:0]        angle,
    output logic signed [IW-1:0] x0,
    output logic signed [IW-1:0] y0,
    output logic [AW-1:0]        z0
);
    localparam int XINIT_I = inv_gain_fixed(STAGES, IFRAC);
    localparam logic signed [IW-1:0] XINIT = IW'(XINIT_I);

    quadrant_e quad;
    logic      outer;

    always_comb begin
        quad  = quadrant_e'(angle[AW-1 -: 2]);
        outer = (quad == QD_SECOND) || (quad == QD_THIRD);
        // a half-turn added to the residual is undone by a negated start vector
        z0    = {angle[AW-1] ^ outer, angle[AW-2:0]};
        x0    = outer ? -XINIT : XINIT;
        y0    = '0;
    end
endmodule

// File: rtl/sincos_stage.sv
module sincos_stage
    import sincos_pkg::*;
#(
    parameter int IDX = 0,
    parameter int IW  = SC_DATA_W + SC_GUARD,
    parameter int AW  = SC_ANGLE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_in,
    input  logic signed [IW-1:0] x_in,
    input  logic signed [IW-1:0] y_in,
    input  logic [AW-1:0]        z_in,
    output logic                 valid_out,
    output logic signed [IW-1:0] x_out,
    output logic signed [IW-1:0] y_out,
    output logic [AW-1:0]        z_out
);
    localparam int ATAN_I = atan_units(IDX, AW);
    localparam logic [AW-1:0] ATAN_K = ATAN_I[AW-1:0];

    logic signed [IW-1:0] x_sh;
    logic signed [IW-1:0] y_sh;
    logic                 ccw;
    logic signed [IW-1:0] x_nx;
    logic signed [IW-1:0] y_nx;
    logic [AW-1:0]        z_nx;

    always_comb begin
        x_sh = x_in >>> IDX;
        y_sh = y_in >>> IDX;
        ccw  = ~z_in[AW-1];
        if (ccw) begin
            x_nx = x_in - y_sh;
            y_nx = y_in + x_sh;
            z_nx = z_in - ATAN_K;
        end else begin
            x_nx = x_in + y_sh;
            y_nx = y_in - x_sh;
            z_nx = z_in + ATAN_K;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_out <= 1'b0;
        else     valid_out <= valid_in;
        x_out <= x_nx;
        y_out <= y_nx;
        z_out <= z_nx;
    end

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (valid_out == $past(valid_in))); // R1
    AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !valid_out); // R6
endmodule

// File: rtl/sincos_pipe.sv
module sincos_pipe
    import sincos_pkg::*;
#(
    parameter int DATA_W  = SC_DATA_W,
    parameter int ANGLE_W = SC_ANGLE_W,
    parameter int STAGES  = SC_STAGES,
    parameter int GUARD   = SC_GUARD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [ANGLE_W-1:0] in_angle,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_sin,
    output logic [DATA_W-1:0]  out_cos
);
    localparam int IW      = DATA_W + GUARD;
    localparam int IFRAC   = DATA_W - 2 + GUARD;
    localparam int HALF_I  = 1 << (GUARD - 1);
    localparam logic signed [IW-1:0] HALF = IW'(HALF_I);
    localparam int ONE_I   = 1 << (DATA_W - 2);
    localparam int AMP_LIM = ONE_I + 16;
    localparam longint ONE_SQ  = longint'(ONE_I) * longint'(ONE_I);
    localparam longint MAG_TOL = ONE_SQ / 64;

    logic                 v_s [STAGES+1];
    logic signed [IW-1:0] x_s [STAGES+1];
    logic signed [IW-1:0] y_s [STAGES+1];
    logic [ANGLE_W-1:0]   z_s [STAGES+1];

    assign v_s[0] = in_valid;

    sincos_fold #(
        .IW(IW), .AW(ANGLE_W), .STAGES(STAGES), .IFRAC(IFRAC)
    ) u_fold (
        .angle (in_angle),
        .x0    (x_s[0]),
        .y0    (y_s[0]),
        .z0    (z_s[0])
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        sincos_stage #(
            .IDX(i), .IW(IW), .AW(ANGLE_W)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .valid_in  (v_s[i]),
            .x_in      (x_s[i]),
            .y_in      (y_s[i]),
            .z_in      (z_s[i]),
            .valid_out (v_s[i+1]),
            .x_out     (x_s[i+1]),
            .y_out     (y_s[i+1]),
            .z_out     (z_s[i+1])
        );
    end

    logic signed [IW-1:0] cos_r;
    logic signed [IW-1:0] sin_r;

    always_comb begin
        cos_r = x_s[STAGES] + HALF;
        sin_r = y_s[STAGES] + HALF;
    end

    assign out_valid = v_s[STAGES];
    assign out_cos   = cos_r[GUARD +: DATA_W];
    assign out_sin   = sin_r[GUARD +: DATA_W];

    logic signed [DATA_W-1:0] s_sig;
    logic signed [DATA_W-1:0] c_sig;
    longint                   mag_sq;

    always_comb begin
        s_sig  = $signed(out_sin);
        c_sig  = $signed(out_cos);
        mag_sq = longint'(s_sig) * longint'(s_sig) + longint'(c_sig) * longint'(c_sig);
    end

    AST_SIN_RANGE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (int'(s_sig) <= AMP_LIM && int'(s_sig) >= -AMP_LIM)); // R4
    AST_COS_RANGE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (int'(c_sig) <= AMP_LIM && int'(c_sig) >= -AMP_LIM)); // R5
    AST_UNIT_MAG: assert property (@(posedge clk) disable iff (rst) out_valid |-> (mag_sq <= ONE_SQ + MAG_TOL && mag_sq >= ONE_SQ - MAG_TOL)); // R8
endmodule

// File: tb/sincos_pipe_bench.sv
module sincos_pipe_bench;
    localparam int  LAT  = 14;
    localparam int  TOL  = 6;
    localparam real PI   = 3.14159265358979323846;
    localparam real ONE  = 16384.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_angle = '0;
    logic        out_valid;
    logic [15:0] out_sin;
    logic [15:0] out_cos;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string ph_tag = "R6";

    logic        ring_v [32];
    logic [15:0] ring_a [32];

    sincos_pipe u_sincos_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
        .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos)
    );

    always #4 clk = ~clk;

    function automatic bit is_corner(input logic [15:0] a);
        return a == 16'h0000 || a == 16'h4000 || a == 16'hC000 || a == 16'h8000
            || a == 16'h3FFF || a == 16'h4001 || a == 16'h7FFF || a == 16'hBFFF;
    endfunction

    // R3: binary angle to radians
    function automatic real to_rad(input logic [15:0] a);
        return $itor($signed(a)) * 2.0 * PI / 65536.0;
    endfunction

    function automatic int ideal(input real v);
        return $rtoi($floor(v * ONE + 0.5));
    endfunction

    task automatic compare(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act > exp + TOL || act < exp - TOL) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic        ev;
        logic [15:0] ea;
        int          es, ec, as_, ac;
        longint      mag;
        ev = 1'b0;
        ea = '0;
        if (cyc >= LAT) begin
            ev = ring_v[(cyc - LAT) % 32];
            ea = ring_a[(cyc - LAT) % 32];
        end
        checks++;
        if (out_valid !== ev) begin
            fails++;
            $display("FAIL %s out_valid at cycle %0d: actual %b expected %b", ph_tag, cyc, out_valid, ev);
        end
        if (ev && out_valid === 1'b1) begin
            es  = ideal($sin(to_rad(ea)));
            ec  = ideal($cos(to_rad(ea)));
            as_ = int'($signed(out_sin));
            ac  = int'($signed(out_cos));
            compare(is_corner(ea) ? "R9" : "R4", $sformatf("sin angle %h", ea), as_, es);
            compare(is_corner(ea) ? "R9" : "R5", $sformatf("cos angle %h", ea), ac, ec);
            mag = longint'(as_) * as_ + longint'(ac) * ac;
            checks++;
            if (mag > 64'sd268435456 + 64'sd4194304 || mag < 64'sd268435456 - 64'sd4194304) begin
                fails++;
                $display("FAIL R8 magnitude angle %h: actual %0d expected %0d", ea, mag, 268435456);
            end
        end
    endtask

    task automatic step(input logic v, input logic [15:0] a, input logic r);
        @(negedge clk);
        cyc++;
        check_outputs();
        rst      = r;
        in_valid = v;
        in_angle = a;
        if (r) for (int k = 0; k < 32; k++) ring_v[k] = 1'b0;
        ring_v[cyc % 32] = v && !r;
        ring_a[cyc % 32] = a;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] corners [8];
        corners = '{16'h0000, 16'h4000, 16'hC000, 16'h8000,
                    16'h3FFF, 16'h4001, 16'h7FFF, 16'hBFFF};
        for (int k = 0; k < 32; k++) begin
            ring_v[k] = 1'b0;
            ring_a[k] = '0;
        end
        // R6: reset state, valid in with reset held must never emerge
        ph_tag = "R6";
        for (int k = 0; k < 6; k++) step(1'b1, 16'(k * 1000), 1'b1);
        // R2: back-to-back sweep over the whole circle, step of 16 codes
        ph_tag = "R2";
        for (int k = 0; k < 4096; k++) step(1'b1, 16'(k * 16), 1'b0);
        // R7: bubbles with junk angles, corners of R9 in the valid slots
        ph_tag = "R7";
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 8; k++) begin
                step(1'b1, corners[k], 1'b0);
                step(1'b0, 16'h5A5A, 1'b0);
                step(1'b1, corners[k] + 16'(r * 3), 1'b0);
            end
        end
        // R1: drain and check the last results land 14 cycles later
        ph_tag = "R1";
        for (int k = 0; k < LAT + 2; k++) step(1'b0, 16'h1234, 1'b0);
        // R6: reset in the middle of a full pipe
        ph_tag = "R6";
        for (int k = 0; k < 20; k++) step(1'b1, 16'(k * 2999), 1'b0);
        step(1'b1, 16'h2222, 1'b1);
        step(1'b1, 16'h3333, 1'b1);
        for (int k = 0; k < LAT + 6; k++) step(1'b0, 16'h7777, 1'b0);
        // R1: single isolated sample after reset
        ph_tag = "R1";
        step(1'b1, 16'h1555, 1'b0);
        for (int k = 0; k < LAT + 3; k++) step(1'b0, 16'h0F0F, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule